// File: doc/BRIEF.md
# S/PDIF Sample-Rate Mode Detector

This block watches a raw biphase-mark audio line and sorts its sample rate into one of seven rate classes. Class 0 is 32 kHz. Classes 1 to 6 are 44.1, 48, 88.2, 96, 176.4 and 192 kHz, in rising order. The line is sampled by a fast reference clock and passed through a two-stage synchroniser. Both rising and falling transitions are detected, and the block counts reference cycles between consecutive transitions.

Over a measurement window of programmable length, the block keeps the shortest such interval. When the window closes, twice that minimum is compared against a chain of boundary thresholds. Each boundary threshold is the sum of the timers of the two adjacent classes. Software supplies one timer per class, normally the reference frequency divided by 128 times that class's rate. It also supplies the window length, normally the reference frequency over 1000.

The block reports the class, the measured minimum width and a window-done pulse. A sticky interrupt status vector flags changes of rate class. A mask then selects which status bits drive the interrupt line.

Top module: `spdif_rate_detect`

## Requirements
- R1: The line input passes through a two-flip-flop synchroniser, and both rising and falling transitions of the synchronised line count as edges.
- R2: The measured width is the smallest number of reference cycles between two consecutive edges whose later edge falls in the window. The interval count saturates at 1023.
- R3: A window lasts `win_len` cycles. At its last cycle the results register, and `status_valid` is high for exactly the one following cycle.
- R4: Boundary threshold i (i = 0..5) is timer[i] + timer[i+1], where timer[i] sits at `mode_timers[8*i+7:8*i]`. The reported class is the lowest i for which 2 × width ≥ threshold[i], or 6 when no boundary is met.
- R5: A window with no measured interval reports class 7 and width 0.
- R6: `mode_out` and `width_out` hold their values in every cycle in which `status_valid` is low.
- R7: Bit 2 of `irq_status` sets at a window end whose class differs from the last class seen with a signal present. That reference class starts at 0 after reset, and windows with no signal leave it alone. A move from silence to class 0 therefore raises nothing.
- R8: Status bits stay set until a 1 is written to the same bit of `irq_clr`. A set in the same cycle as a clear wins.
- R9: `irq` is the OR of `irq_status & irq_mask`.
- R10: After reset, `mode_out` is 7, `width_out` is 0, and `status_valid`, `irq_status` and `irq` are 0.
- R11: The running minimum restarts at the start of every window, so a short interval in one window does not affect the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Raw asynchronous S/PDIF line |
| win_len | input | 20 | Window length in reference cycles |
| mode_timers | input | 56 | Seven 8-bit per-class timers, class i at bits 8i+7:8i |
| irq_mask | input | 8 | Enable mask for the interrupt line |
| irq_clr | input | 8 | Write-one-to-clear pulses for status bits |
| mode_out | output | 3 | Detected class, 7 = no signal |
| width_out | output | 10 | Minimum edge-to-edge width of last window, 0 = no signal |
| status_valid | output | 1 | One-cycle pulse when results update |
| irq_status | output | 8 | Sticky interrupt status, bit 2 = class changed |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench builds the block with its default parameters: 20-bit window, 10-bit counter, 8-bit timers, seven classes. It then scales the timers down (20, 14, 13, 7, 6, 3, 3) and runs 64-cycle windows. At that scale every class, including the exact equality point at a boundary, is reached with half-periods of 2 to 20 cycles. A single long 3000-cycle window with a 1500-cycle half-period then drives the interval counter into saturation.

// File: rtl/spdif_det_pkg.sv
package spdif_det_pkg;
  localparam int          MODE_W       = 3;
  localparam logic [2:0]  MODE_NONE    = 3'd7;
  localparam int          IRQ_MODE_BIT = 2;
endpackage

// File: rtl/spdif_edge_sync.sv
module spdif_edge_sync #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_in,
  output logic             edge_o,
  output logic             prev_ok_o,
  output logic [CNT_W-1:0] gap_o
);
  localparam logic [CNT_W-1:0] GAP_MAX = '1;

  logic [2:0]       sh;
  logic [CNT_W-1:0] gap;
  logic             prev_ok;

  // sh[0], sh[1] form the synchroniser; sh[2] keeps last synced value
  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[1:0], line_in};
  end

  assign edge_o = sh[1] ^ sh[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      gap     <= '0;
      prev_ok <= 1'b0;
    end else begin
      if (edge_o) begin
        gap     <= {{(CNT_W-1){1'b0}}, 1'b1};
        prev_ok <= 1'b1;
      end else if (gap != GAP_MAX) begin
        gap <= gap + 1'b1;
      end
    end
  end

  assign gap_o     = gap;
  assign prev_ok_o = prev_ok;

  // R2: counter holds at its ceiling until an edge arrives
  p_gap_saturates_r2: assert property (@(posedge clk) disable iff (rst)
    (gap == GAP_MAX && !edge_o) |=> (gap == GAP_MAX));
endmodule

// File: rtl/spdif_min_tracker.sv
module spdif_min_tracker #(
  parameter int WIN_W = 20,
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIN_W-1:0] win_len,
  input  logic             edge_i,
  input  logic             prev_ok_i,
  input  logic [CNT_W-1:0] gap_i,
  output logic             win_end_o,
  output logic [CNT_W-1:0] min_o,
  output logic             seen_o
);
  logic [WIN_W-1:0] wcnt;
  logic [CNT_W-1:0] minw;
  logic             seen;
  logic             ev;
  logic [WIN_W:0]   wnext;

  assign wnext     = {1'b0, wcnt} + {{WIN_W{1'b0}}, 1'b1};
  assign win_end_o = (wnext >= {1'b0, win_len});
  assign ev        = edge_i & prev_ok_i;
  assign min_o     = (ev && gap_i < minw) ? gap_i : minw;
  assign seen_o    = seen | ev;

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt <= '0;
      minw <= '1;
      seen <= 1'b0;
    end else if (win_end_o) begin
      wcnt <= '0;
      minw <= '1;
      seen <= 1'b0;
    end else begin
      wcnt <= wnext[WIN_W-1:0];
      minw <= min_o;
      seen <= seen_o;
    end
  end

  // R11: within a window the running minimum never grows
  p_min_monotone_r11: assert property (@(posedge clk) disable iff (rst)
    !win_end_o |=> (minw <= $past(minw)));
  // R11: each window starts from an empty minimum
  p_min_restart_r11: assert property (@(posedge clk) disable iff (rst)
    win_end_o |=> (minw == '1 && !seen));
endmodule

// File: rtl/spdif_mode_classifier.sv
module spdif_mode_classifier
  import spdif_det_pkg::*;
#(
  parameter int NUM_MODES = 7,
  parameter int TMR_W     = 8,
  parameter int THR_W     = 10,
  parameter int CNT_W     = 10
) (
  input  logic [NUM_MODES*TMR_W-1:0] timers,
  input  logic [CNT_W-1:0]           width,
  input  logic                       seen,
  output logic [MODE_W-1:0]          mode
);
  localparam int CMP_W = (CNT_W + 1 > THR_W) ? CNT_W + 1 : THR_W;

  logic [CMP_W-1:0]     dbl;
  logic [NUM_MODES-2:0] pass;

  assign dbl = CMP_W'({width, 1'b0});

  for (genvar i = 0; i < NUM_MODES - 1; i++) begin : g_bound
    logic [THR_W-1:0] thr;
    assign thr     = THR_W'(timers[i*TMR_W +: TMR_W]) +
                     THR_W'(timers[(i+1)*TMR_W +: TMR_W]);
    assign pass[i] = (dbl >= CMP_W'(thr));
  end

  always_comb begin
    mode = MODE_W'(NUM_MODES - 1);
    for (int i = NUM_MODES - 2; i >= 0; i--) begin
      if (pass[i]) mode = MODE_W'(i);
    end
    if (!seen) mode = MODE_NONE;
  end
endmodule

// File: rtl/spdif_rate_detect.sv
module spdif_rate_detect
  import spdif_det_pkg::*;
#(
  parameter int WIN_W     = 20,
  parameter int CNT_W     = 10,
  parameter int TMR_W     = 8,
  parameter int THR_W     = 10,
  parameter int IRQ_W     = 8,
  parameter int NUM_MODES = 7
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       line_in,
  input  logic [WIN_W-1:0]           win_len,
  input  logic [NUM_MODES*TMR_W-1:0] mode_timers,
  input  logic [IRQ_W-1:0]           irq_mask,
  input  logic [IRQ_W-1:0]           irq_clr,
  output logic [MODE_W-1:0]          mode_out,
  output logic [CNT_W-1:0]           width_out,
  output logic                       status_valid,
  output logic [IRQ_W-1:0]           irq_status,
  output logic                       irq
);
  logic             edge_s, prev_ok;
  logic [CNT_W-1:0] gap;
  logic             win_end, seen;
  logic [CNT_W-1:0] wmin;
  logic [MODE_W-1:0] cls_mode;
  logic [MODE_W-1:0] last_rate;
  logic [IRQ_W-1:0]  set_vec;

  spdif_edge_sync #(.CNT_W(CNT_W)) u_sync (
    .clk(clk), .rst(rst), .line_in(line_in),
    .edge_o(edge_s), .prev_ok_o(prev_ok), .gap_o(gap)
  );

  spdif_min_tracker #(.WIN_W(WIN_W), .CNT_W(CNT_W)) u_track (
    .clk(clk), .rst(rst), .win_len(win_len),
    .edge_i(edge_s), .prev_ok_i(prev_ok), .gap_i(gap),
    .win_end_o(win_end), .min_o(wmin), .seen_o(seen)
  );

  spdif_mode_classifier #(
    .NUM_MODES(NUM_MODES), .TMR_W(TMR_W), .THR_W(THR_W), .CNT_W(CNT_W)
  ) u_cls (
    .timers(mode_timers), .width(wmin), .seen(seen), .mode(cls_mode)
  );

  always_comb begin
    set_vec = '0;
    set_vec[IRQ_MODE_BIT] = win_end && seen && (cls_mode != last_rate);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_out     <= MODE_NONE;
      width_out    <= '0;
      status_valid <= 1'b0;
      last_rate    <= '0;
      irq_status   <= '0;
    end else begin
      status_valid <= win_end;
      irq_status   <= (irq_status & ~irq_clr) | set_vec;
      if (win_end) begin
        mode_out  <= cls_mode;
        width_out <= seen ? wmin : '0;
        if (seen) last_rate <= cls_mode;
      end
    end
  end

  assign irq = |(irq_status & irq_mask);

  // R5: class 7 and zero width always appear together
  p_nosig_pair_r5: assert property (@(posedge clk) disable iff (rst)
    (mode_out == MODE_NONE) == (width_out == '0));
  // R6: outputs only move alongside the done pulse
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !status_valid |-> ($stable(mode_out) && $stable(width_out)));
  // R7: change flag only rises with a window result
  p_irq_at_window_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_status[IRQ_MODE_BIT]) |-> status_valid);
  // R8: a set bit survives unless cleared
  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (irq_status[IRQ_MODE_BIT] && !irq_clr[IRQ_MODE_BIT]) |=> irq_status[IRQ_MODE_BIT]);
endmodule

// File: tb/spdif_rate_detect_test.sv
module spdif_rate_detect_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        line_in = 1'b0;
  logic [19:0] win_len = 20'd64;
  logic [55:0] mode_timers;
  logic [7:0]  irq_mask = 8'h04;
  logic [7:0]  irq_clr = 8'h00;
  logic [2:0]  mode_out;
  logic [9:0]  width_out;
  logic        status_valid;
  logic [7:0]  irq_status;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  int half   = 0;
  bit cmp_en = 0;
  int tmr [7] = '{20, 14, 13, 7, 6, 3, 3};

  always #2 clk = ~clk;

  spdif_rate_detect uut (
    .clk(clk), .rst(rst), .line_in(line_in), .win_len(win_len),
    .mode_timers(mode_timers), .irq_mask(irq_mask), .irq_clr(irq_clr),
    .mode_out(mode_out), .width_out(width_out), .status_valid(status_valid),
    .irq_status(irq_status), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int classify(input int w);
    for (int i = 0; i < 6; i++)
      if (2 * w >= tmr[i] + tmr[i+1]) return i;
    return 6;
  endfunction

  // behavioural reference model
  int hist[$] = '{0, 0, 0};
  int m_gap = 0, m_prev = 0, m_wc = 0, m_minw = 1023, m_seen = 0;
  int m_mode = 7, m_width = 0, m_valid = 0, m_last = 0;
  logic [7:0] m_irq = 8'h00;

  always @(posedge clk) begin
    if (rst) begin
      hist = '{0, 0, 0};
      m_gap = 0; m_prev = 0; m_wc = 0; m_minw = 1023; m_seen = 0;
      m_mode = 7; m_width = 0; m_valid = 0; m_last = 0; m_irq = 8'h00;
    end else begin
      bit e, ev, wend;
      logic [7:0] setv;
      int fm, fs, cm;
      e    = (hist[1] != hist[2]);
      ev   = e && (m_prev != 0);
      wend = (m_wc + 1 >= int'(win_len));
      fm   = (ev && m_gap < m_minw) ? m_gap : m_minw;
      fs   = (m_seen != 0 || ev) ? 1 : 0;
      setv = 8'h00;
      if (wend) begin
        cm = fs ? classify(fm) : 7;
        if (fs && cm != m_last) setv[2] = 1'b1;
        if (fs) m_last = cm;
        m_mode = cm;
        m_width = fs ? fm : 0;
        m_valid = 1;
        m_wc = 0; m_minw = 1023; m_seen = 0;
      end else begin
        m_valid = 0;
        m_wc++; m_minw = fm; m_seen = fs;
      end
      m_irq = (m_irq & ~irq_clr) | setv;
      if (e) begin m_gap = 1; m_prev = 1; end
      else if (m_gap < 1023) m_gap++;
      hist.push_front(int'(line_in));
      void'(hist.pop_back());
      cmp_en = 1;
    end
  end

  always @(negedge clk) begin
    if (cmp_en && !rst) begin
      chk("R4 mode_out", mode_out, m_mode);
      chk("R2 width_out", width_out, m_width);
      chk("R3 status_valid", status_valid, m_valid);
      chk("R8 irq_status", irq_status, m_irq);
      chk("R9 irq", irq, (m_irq & irq_mask) != 0);
    end
  end

  // line driver: toggles every 'half' cycles, silent when half is 0
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (half > 0) begin
        cnt++;
        if (cnt >= half) begin line_in = ~line_in; cnt = 0; end
      end else cnt = 0;
    end
  end

  task automatic wait_win(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      while (!status_valid) @(negedge clk);
    end
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual timeout expected completion");
    report();
  end

  initial begin
    for (int i = 0; i < 7; i++) mode_timers[i*8 +: 8] = 8'(tmr[i]);
    repeat (4) @(negedge clk);
    // R10 reset state
    chk("R10 mode", mode_out, 7);
    chk("R10 width", width_out, 0);
    chk("R10 valid", status_valid, 0);
    chk("R10 irq_status", irq_status, 0);
    chk("R10 irq", irq, 0);
    rst = 1'b0;

    // R5 silence
    wait_win(2);
    chk("R5 mode none", mode_out, 7);
    chk("R5 width none", width_out, 0);

    // R1/R4 slowest class; R7 silence to class 0 raises nothing
    half = 20;
    wait_win(3);
    chk("R1 width both edges", width_out, 20);
    chk("R4 class 0", mode_out, 0);
    chk("R7 no irq on silence to 0", irq_status, 0);

    // R3 window period
    begin
      int c = 0;
      @(negedge clk);
      while (!status_valid) begin c++; @(negedge clk); end
      chk("R3 window length", c + 1, 64);
    end

    // R4 exact boundary, R7 change, R9 masking
    half = 10;
    wait_win(3);
    chk("R4 class 2 at equality", mode_out, 2);
    chk("R7 change flagged", irq_status[2], 1);
    chk("R9 irq on", irq, 1);
    irq_mask = 8'h00;
    @(negedge clk);
    chk("R9 masked", irq, 0);
    irq_mask = 8'h04;

    // R6 hold between windows
    begin
      logic [2:0] mo;
      mo = mode_out;
      repeat (5) @(negedge clk);
      if (!status_valid) chk("R6 hold", mode_out, mo);
    end

    // R8 write-one-to-clear
    irq_clr = 8'h04;
    @(negedge clk);
    irq_clr = 8'h00;
    chk("R8 cleared", irq_status, 0);
    repeat (3) @(negedge clk);
    chk("R8 stays clear", irq_status, 0);

    half = 9;  wait_win(3); chk("R4 class 3", mode_out, 3);
    half = 4;  wait_win(3); chk("R4 class 5", mode_out, 5);
    half = 2;  wait_win(3); chk("R4 class 6", mode_out, 6);
    // R11 short interval must not leak into later window
    half = 20; wait_win(3);
    chk("R11 restart width", width_out, 20);
    chk("R11 restart class", mode_out, classify(20));

    // R2 saturation
    win_len = 20'd3000;
    half = 1500;
    wait_win(4);
    chk("R2 saturated width", width_out, 1023);

    // R7 silence then class 0 again: no new flag
    irq_clr = 8'hFF;
    @(negedge clk);
    irq_clr = 8'h00;
    win_len = 20'd64;
    half = 0;
    wait_win(3);
    chk("R5 silence again", mode_out, 7);
    half = 20;
    wait_win(3);
    chk("R7 same class after gap", irq_status[2], 0);

    report();
  end
endmodule